// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive approximation analog-to-digital converter. A pulse on `start_i` opens a conversion. The block then runs a binary search over a parameterised N-bit code. In each step it puts one more bit into the trial code on `dac_code_o`, which drives an external DAC. It then reads back a one-bit comparator verdict on `cmp_hi_i` and decides that bit. The search goes from the most significant bit down to the least significant bit, one bit per clock. A whole conversion therefore takes N cycles, against up to 2^N − 1 cycles for a counting converter.

When the last bit is decided, the finished code goes into a separate result register, and `done_o` pulses for one cycle. The result register changes only at that moment. A downstream reader can therefore take the previous sample at leisure while the next conversion is already running. The comparator input is synchronous: it is sampled on the rising edge that closes each trial cycle. It reads 1 when the analog input is at or above the level the current trial code produces.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `dac_code_o`, `result_o`, `done_o` and `busy_o` are all 0 until a conversion is started.
- R2: A `start_i` high at a rising edge while the block is idle (neither busy nor in its done cycle) is accepted. In the next cycle `busy_o` is 1 and `dac_code_o` has only bit N−1 set (128 for N = 8).
- R3: Bits are tried from bit N−1 down to bit 0, one per cycle. In trial k (k = 0 first), bit N−1−k of `dac_code_o` is 1 and every lower bit is 0.
- R4: At the edge that closes a trial, the bit under test keeps the value of `cmp_hi_i` (1 = keep the bit set, 0 = clear it). Bits above it keep their decided values. With a comparator that reports input code ≥ trial code, the final result equals the input code.
- R5: `done_o` is high for exactly one cycle. It rises on the N-th rising edge after the edge that accepted `start_i`. `busy_o` is 0 while `done_o` is 1.
- R6: `result_o` takes the final code in the cycle in which `done_o` is high, and it keeps its value in every other cycle, including the whole of the next conversion.
- R7: A `start_i` during a conversion, or during the done cycle, is ignored. The running conversion keeps its trial codes, result and timing, and the block is idle in the cycle after `done_o`.
- R8: Whenever `busy_o` is 0, `dac_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a conversion |
| cmp_hi_i | input | 1 | Comparator verdict: 1 when the analog input is at or above the trial level |
| dac_code_o | output | N | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | N | Last finished conversion result |

## Verification
The assertions check four things on every cycle. The DAC code is zero whenever the block is idle. Done lasts one cycle and never overlaps busy. The result register holds outside the done cycle. An accepted start always opens with the most significant bit alone.

The bench's scenarios cover the rest: every 8-bit input code, checked against the trial code at each step of the search. That shows the MSB-first order, the keep-or-clear decision, the final value and the exact N-cycle latency. Start requests placed in the middle of a conversion and in the done cycle show that they are ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_DONE  = 2'd2
    } sar_state_e;

    typedef struct packed {
        logic load;   // accept start: seed the MSB trial
        logic step;   // a trial is being decided this cycle
        logic last;   // the trial being decided is bit 0
    } sar_ctl_t;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    output sar_ctl_t     ctl_o,
    output logic [N-1:0] mask_o,
    output logic         busy_o,
    output logic         done_o
);
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    sar_state_e   state_q;
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_TRIAL;
                        mask_q  <= MSB_ONLY;
                    end
                end
                ST_TRIAL: begin
                    if (mask_q[0]) begin
                        state_q <= ST_DONE;
                        mask_q  <= '0;
                    end else begin
                        mask_q <= mask_q >> 1;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                    mask_q  <= '0;
                end
            endcase
        end
    end

    always_comb begin
        ctl_o.load = (state_q == ST_IDLE) && start_i;
        ctl_o.step = (state_q == ST_TRIAL);
        ctl_o.last = (state_q == ST_TRIAL) && mask_q[0];
    end

    assign mask_o = mask_q;
    assign busy_o = (state_q == ST_TRIAL);
    assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/sar_work_reg.sv
module sar_work_reg
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sar_ctl_t     ctl_i,
    input  logic [N-1:0] mask_i,
    input  logic         cmp_hi_i,
    output logic [N-1:0] trial_o,
    output logic [N-1:0] final_o
);
    logic [N-1:0] work_q;
    logic [N-1:0] decided;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Value of this bit once the current trial is resolved.
        assign decided[i] = mask_i[i] ? cmp_hi_i : work_q[i];

        if (i == N - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst)                             work_q[i] <= 1'b0;
                else if (ctl_i.load)                 work_q[i] <= 1'b1;
                else if (ctl_i.step && ctl_i.last)   work_q[i] <= 1'b0;
                else if (ctl_i.step)                 work_q[i] <= decided[i];
            end
        end else begin : g_low
            always_ff @(posedge clk) begin
                if (rst)                             work_q[i] <= 1'b0;
                else if (ctl_i.load)                 work_q[i] <= 1'b0;
                else if (ctl_i.step && ctl_i.last)   work_q[i] <= 1'b0;
                else if (ctl_i.step)                 work_q[i] <= decided[i] | mask_i[i+1];
            end
        end
    end

    assign trial_o = work_q;
    assign final_o = decided;

endmodule

// File: rtl/sar_hold_reg.sv
module sar_hold_reg
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sar_ctl_t     ctl_i,
    input  logic [N-1:0] final_i,
    output logic [N-1:0] result_o
);
    logic [N-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)             hold_q <= '0;
        else if (ctl_i.last) hold_q <= final_i;
    end

    assign result_o = hold_q;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         cmp_hi_i,
    output logic [N-1:0] dac_code_o,
    output logic         busy_o,
    output logic         done_o,
    output logic [N-1:0] result_o
);
    sar_ctl_t     ctl;
    logic [N-1:0] mask;
    logic [N-1:0] final_code;

    initial begin
        if (N < 2) $error("sar_adc_ctrl: N must be at least 2");
    end

    sar_seq #(.N(N)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (ctl),
        .mask_o  (mask),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    sar_work_reg #(.N(N)) u_work (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl),
        .mask_i   (mask),
        .cmp_hi_i (cmp_hi_i),
        .trial_o  (dac_code_o),
        .final_o  (final_code)
    );

    sar_hold_reg #(.N(N)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl),
        .final_i  (final_code),
        .result_o (result_o)
    );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [N-1:0] dac_code_o,
    input logic         busy_o,
    input logic         done_o,
    input logic [N-1:0] result_o
);
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    assert_start_msb_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !done_o) |=> (busy_o && dac_code_o == MSB_ONLY));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    assert_idle_dac_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (dac_code_o == '0));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .dac_code_o (dac_code_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         cmp_hi_i;
    logic [N-1:0] vin = '0;
    logic [N-1:0] dac_code_o;
    logic         busy_o;
    logic         done_o;
    logic [N-1:0] result_o;

    int n_total = 0;
    int n_fail  = 0;
    logic [N-1:0] sb_q[$];
    logic [N-1:0] held = '0;
    logic         prev_done = 1'b0;
    logic         mon_on = 1'b0;

    always #5ns clk = ~clk;

    // Comparator model: input code at or above the trial code.
    always_comb cmp_hi_i = (vin >= dac_code_o);

    sar_adc_ctrl #(.N(N)) u_sar_adc_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmp_hi_i   (cmp_hi_i),
        .dac_code_o (dac_code_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops the scoreboard when done arrives, checks the result holds otherwise.
    always @(negedge clk) begin
        if (mon_on) begin
            if (done_o) begin
                check(!prev_done, "R5 done one cycle", 1, 0);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5 unexpected done", 1, 0);
                end else begin
                    logic [N-1:0] exp_code;
                    exp_code = sb_q.pop_front();
                    check(result_o == exp_code, "R4 R6 result", int'(result_o), int'(exp_code));
                end
                held = result_o;
            end else begin
                check(result_o == held, "R6 result held", int'(result_o), int'(held));
            end
            prev_done = done_o;
        end
    end

    // Driver: one conversion, checking each trial code; optional stray starts.
    task automatic convert(input logic [N-1:0] code, input bit poke);
        @(negedge clk);
        vin = code;
        start_i = 1'b1;
        sb_q.push_back(code);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < N; k++) begin
            logic [N-1:0] hi;
            logic [N-1:0] trial;
            logic [N-1:0] exp_dac;
            hi = ~({N{1'b1}} >> k);
            trial = {{(N-1){1'b0}}, 1'b1} << (N - 1 - k);
            exp_dac = (code & hi) | trial;
            if (k == 0) check(dac_code_o == trial, "R2 first trial MSB", int'(dac_code_o), int'(trial));
            check(dac_code_o == exp_dac, "R3 R4 trial code", int'(dac_code_o), int'(exp_dac));
            check(busy_o == 1'b1, "R2 busy during trial", int'(busy_o), 1);
            check(done_o == 1'b0, "R5 no early done", int'(done_o), 0);
            start_i = (poke && k == 2);   // R7 stray start mid-conversion
            @(negedge clk);
        end
        check(done_o == 1'b1, "R5 done after N edges", int'(done_o), 1);
        check(busy_o == 1'b0, "R5 not busy in done cycle", int'(busy_o), 0);
        check(dac_code_o == '0, "R8 dac zero in done cycle", int'(dac_code_o), 0);
        start_i = poke;                    // R7 stray start in done cycle
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b0, "R7 start ignored, idle", int'(busy_o), 0);
        check(done_o == 1'b0, "R5 done dropped", int'(done_o), 0);
        check(dac_code_o == '0, "R8 dac zero idle", int'(dac_code_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dac_code_o == '0, "R1 reset dac", int'(dac_code_o), 0);
        check(result_o == '0, "R1 reset result", int'(result_o), 0);
        check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
        check(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(dac_code_o == '0 && busy_o == 1'b0, "R1 idle after reset", int'(dac_code_o), 0);
        mon_on = 1'b1;
        // Boundary codes first, then every code, with stray starts on some.
        convert('0, 1'b1);
        convert({N{1'b1}}, 1'b1);
        convert({1'b1, {(N-1){1'b0}}}, 1'b0);
        convert({1'b0, {(N-1){1'b1}}}, 1'b1);
        for (int c = 0; c < (1 << N); c++) begin
            convert(N'(c), (c % 7) == 3);
        end
        @(negedge clk);
        check(sb_q.size() == 0, "R5 every conversion completed", sb_q.size(), 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #1ms;
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule